// File: doc/BRIEF.md
# Static-Way-Preferring Insertion Policy with Remap Cap

This block chooses where a missing line goes inside one set of a set-associative cache. Every line has a preferred way computed from its address, called its static way. The block keeps, for each set and way, a valid bit, a 2-bit re-reference prediction value (RRPV) and a flag telling whether the resident line sits outside its static way. It also keeps a per-set count of such displaced lines. A hit request resets the RRPV of the way that hit. A miss request starts a short decision sequence. The sequence returns the way to fill, whether the new line is displaced, whether a valid line is overwritten, and whether the choice was random. The block then installs the new line in that way.

The block favours the static way strongly. It evicts the occupant of the static way as soon as that occupant's RRPV reaches 2, not only when the RRPV saturates. When the occupant still looks useful, the new line is placed in another way. The number of displaced lines in a set is capped by the `remap_limit` input. At the cap, only displaced lines can be victims.

The control is a four-state machine:
- ST_IDLE accepts requests. A hit is handled in place and stays in ST_IDLE. An accepted miss moves to ST_DECIDE.
- ST_DECIDE either resolves the victim and moves to ST_RESP, or finds no eligible saturated way and moves to ST_AGE.
- ST_AGE ages the eligible ways by one and returns to ST_DECIDE.
- ST_RESP presents the result for one cycle and returns to ST_IDLE.

Top module: `remap_rrip_insert`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` is 0. Every way of every set is empty, so the first miss to any set never reports an eviction.
- R2: When the static way of a missing line is empty, the response names the static way, with `resp_remapped`=0 and `resp_evicted`=0.
- R3: When the static way holds a valid line whose RRPV is 2 or 3, that way is the victim, with `resp_remapped`=0 and `resp_evicted`=1.
- R4: When the static occupant's RRPV is 0 or 1 and displacement is allowed, the victim is a different way and `resp_remapped`=1.
- R5: While the set's count of displaced lines is below `remap_limit`, the victim is chosen among the other ways as follows. The lowest-index empty way is taken first (`resp_evicted`=0). Otherwise the lowest-index way with RRPV 3 is taken.
- R6: If none of the other ways is empty or at RRPV 3, all of them are incremented by one and the search repeats. Each round adds two cycles: the response appears 2+2·n falling edges after acceptance for n rounds. The static way is never aged.
- R7: When the displaced count is at or above `remap_limit`, the victim is chosen only among valid displaced lines other than the static way. The lowest-index one with RRPV 3 is preferred, with `resp_random`=0.
- R8: If no such displaced line has RRPV 3, one is picked at random and `resp_random`=1. The random source is an 8-bit register seeded to 0xA5 at reset. It advances only on a random pick, to {r[6:0], r[7]^r[5]^r[4]^r[3]}. The start index s is the low log2(ways) bits of that register. The victim is the first displaced candidate at positions (s+k) mod ways, for k = 0, 1, ….
- R9: At or above the limit with no displaced candidate, the static occupant is evicted anyway (`resp_remapped`=0, `resp_evicted`=1).
- R10: An installed line gets RRPV 2 and a displaced flag equal to `resp_remapped`. The per-set count always equals the number of valid displaced lines in the set.
- R11: A hit request (`req_miss`=0) to a valid way sets that way's RRPV to 0. It produces no response, and `req_ready` stays 1. A hit to an empty way has no effect.
- R12: `req_ready` is 0 from the cycle after a miss is accepted until the response. `resp_valid` is high for exactly one cycle, after which `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| remap_limit | input | CNT_W | Maximum number of displaced lines per set |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_miss | input | 1 | 1 = miss (allocate), 0 = hit update |
| req_set | input | SET_W | Set index |
| req_way | input | WAY_W | Static way for a miss, way that hit for a hit |
| resp_valid | output | 1 | Decision result valid (one cycle) |
| resp_way | output | WAY_W | Way chosen for the new line |
| resp_remapped | output | 1 | New line placed outside its static way |
| resp_evicted | output | 1 | Chosen way held a valid line |
| resp_random | output | 1 | Victim chosen by the random source |

## Verification
The assertions check four properties on every cycle:
- the per-set displaced count always matches the valid displaced flags;
- a non-displaced result always names the static way, and a displaced one never does;
- aging never starts while an eligible way is already saturated;
- displacing never lifts a set's count past the limit.

Only the bench's scenarios can show that the chosen way is right. The bench compares the lowest-index and random choices, the aging latency, the effect of hits on later decisions, and the behaviour at every limit value from zero to the way count. It does this against an arithmetic model of the sets and the random register.

// File: rtl/remap_rrip_pkg.sv
package remap_rrip_pkg;
    localparam logic [1:0] RRPV_MAX  = 2'd3;
    localparam logic [1:0] RRPV_INS  = 2'd2;
    localparam logic [1:0] RRPV_HIT  = 2'd0;
    localparam logic [1:0] RRPV_KICK = 2'd2;
    localparam int         RND_W     = 8;
    localparam logic [7:0] RND_SEED  = 8'hA5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_AGE,
        ST_RESP
    } fsm_t;
endpackage

// File: rtl/rr_lfsr.sv
module rr_lfsr
    import remap_rrip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [RND_W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= RND_SEED;
        end else if (step) begin
            value <= {value[6:0], value[7] ^ value[5] ^ value[4] ^ value[3]};
        end
    end

    // R8: the random source must never lock up at zero
    assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        value != '0);
endmodule

// File: rtl/rr_first_pick.sv
module rr_first_pick #(
    parameter  int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] cand,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] idx
);
    int p;
    always_comb begin
        found = 1'b0;
        idx   = '0;
        p     = 0;
        for (int k = N - 1; k >= 0; k--) begin
            p = (int'(start) + k) % N;
            if (cand[p]) begin
                found = 1'b1;
                idx   = W'(p);
            end
        end
    end
endmodule

// File: rtl/remap_rrip_insert.sv
module remap_rrip_insert
    import remap_rrip_pkg::*;
#(
    parameter  int SETS  = 4,
    parameter  int WAYS  = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] remap_limit,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_miss,
    input  logic [SET_W-1:0] req_set,
    input  logic [WAY_W-1:0] req_way,
    output logic             resp_valid,
    output logic [WAY_W-1:0] resp_way,
    output logic             resp_remapped,
    output logic             resp_evicted,
    output logic             resp_random
);
    fsm_t state_q, state_d;

    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  remap_q [SETS];
    logic [1:0]       rrpv_q  [SETS][WAYS];
    logic [CNT_W-1:0] cnt_q   [SETS];

    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;
    logic [WAY_W-1:0] rsp_way_q;
    logic             rsp_remap_q, rsp_evict_q, rsp_rand_q;

    logic [WAYS-1:0] cur_valid, cur_remap, sat_vec, oth;
    logic [WAYS-1:0] inv_cand, sat_oth, rm_cand, sat_rm;
    logic            st_occ, at_limit;
    logic [1:0]      st_rr;
    logic            inv_f, sat_f, satrm_f, rnd_f;
    logic [WAY_W-1:0] inv_i, sat_i, satrm_i, rnd_i;
    logic [RND_W-1:0] rnd_val;

    logic [WAY_W-1:0] dec_way;
    logic             dec_remap, dec_evict, dec_rand, dec_age;

    assign cur_valid = valid_q[set_q];
    assign cur_remap = remap_q[set_q];
    assign oth       = ~(WAYS'(1) << way_q);
    assign st_occ    = cur_valid[way_q];
    assign st_rr     = rrpv_q[set_q][way_q];
    assign at_limit  = cnt_q[set_q] >= remap_limit;

    for (genvar w = 0; w < WAYS; w++) begin : g_sat
        assign sat_vec[w] = (rrpv_q[set_q][w] == RRPV_MAX);
    end

    assign inv_cand = ~cur_valid & oth;
    assign sat_oth  = sat_vec & oth;
    assign rm_cand  = cur_remap & cur_valid & oth;
    assign sat_rm   = sat_vec & rm_cand;

    rr_first_pick #(.N(WAYS)) u_pick_inv (
        .cand(inv_cand), .start('0), .found(inv_f), .idx(inv_i));
    rr_first_pick #(.N(WAYS)) u_pick_sat (
        .cand(sat_oth), .start('0), .found(sat_f), .idx(sat_i));
    rr_first_pick #(.N(WAYS)) u_pick_satrm (
        .cand(sat_rm), .start('0), .found(satrm_f), .idx(satrm_i));
    rr_first_pick #(.N(WAYS)) u_pick_rnd (
        .cand(rm_cand), .start(rnd_val[WAY_W-1:0]), .found(rnd_f), .idx(rnd_i));

    rr_lfsr u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (state_q == ST_DECIDE && !dec_age && dec_rand),
        .value(rnd_val)
    );

    // victim decision for the captured miss
    always_comb begin
        dec_way   = way_q;
        dec_remap = 1'b0;
        dec_evict = 1'b0;
        dec_rand  = 1'b0;
        dec_age   = 1'b0;
        if (!st_occ) begin
            dec_way = way_q;
        end else if (st_rr >= RRPV_KICK) begin
            dec_evict = 1'b1;
        end else if (at_limit) begin
            dec_evict = 1'b1;
            if (satrm_f) begin
                dec_way   = satrm_i;
                dec_remap = 1'b1;
            end else if (rnd_f) begin
                dec_way   = rnd_i;
                dec_remap = 1'b1;
                dec_rand  = 1'b1;
            end
        end else if (inv_f) begin
            dec_way   = inv_i;
            dec_remap = 1'b1;
        end else if (sat_f) begin
            dec_way   = sat_i;
            dec_remap = 1'b1;
            dec_evict = 1'b1;
        end else begin
            dec_age = 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid && req_miss) state_d = ST_DECIDE;
            ST_DECIDE: state_d = dec_age ? ST_AGE : ST_RESP;
            ST_AGE:    state_d = ST_DECIDE;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-set storage and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                remap_q[s] <= '0;
                cnt_q[s]   <= '0;
                for (int w = 0; w < WAYS; w++) rrpv_q[s][w] <= RRPV_MAX;
            end
            set_q       <= '0;
            way_q       <= '0;
            rsp_way_q   <= '0;
            rsp_remap_q <= 1'b0;
            rsp_evict_q <= 1'b0;
            rsp_rand_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                if (req_miss) begin
                    set_q <= req_set;
                    way_q <= req_way;
                end else if (valid_q[req_set][req_way]) begin
                    rrpv_q[req_set][req_way] <= RRPV_HIT;
                end
            end
            if (state_q == ST_AGE) begin
                for (int w = 0; w < WAYS; w++)
                    if (oth[w]) rrpv_q[set_q][w] <= rrpv_q[set_q][w] + 2'd1;
            end
            if (state_q == ST_DECIDE && !dec_age) begin
                valid_q[set_q][dec_way] <= 1'b1;
                remap_q[set_q][dec_way] <= dec_remap;
                rrpv_q[set_q][dec_way]  <= RRPV_INS;
                cnt_q[set_q] <= cnt_q[set_q] + CNT_W'(dec_remap)
                              - CNT_W'(dec_evict & cur_remap[dec_way]);
                rsp_way_q   <= dec_way;
                rsp_remap_q <= dec_remap;
                rsp_evict_q <= dec_evict;
                rsp_rand_q  <= dec_rand;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        resp_valid    = (state_q == ST_RESP);
        resp_way      = rsp_way_q;
        resp_remapped = rsp_remap_q;
        resp_evicted  = rsp_evict_q;
        resp_random   = rsp_rand_q;
    end

    // R10: counter kept in step with the displaced flags of valid ways
    for (genvar g = 0; g < SETS; g++) begin : g_chk
        assert_count_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt_q[g]) == $countones(remap_q[g] & valid_q[g]));
    end

    // R2: a non-displaced result always names the static way
    assert_static_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_remapped) |-> (resp_way == way_q));

    // R4: a displaced result never names the static way
    assert_remap_offstatic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_remapped) |-> (resp_way != way_q));

    // R6: aging only runs when no eligible way is saturated
    assert_age_unsat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AGE) |-> ((sat_vec & oth) == '0));

    // R7: displacing never lifts the count above the limit
    assert_limit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_remapped) |-> ((cnt_q[set_q] <= remap_limit) || $stable(cnt_q[set_q])));

    // R12: response is a single-cycle pulse
    assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
endmodule

// File: tb/remap_rrip_insert_bench.sv
module remap_rrip_insert_bench;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int CNT_W = $clog2(WAYS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] remap_limit = '0;
    logic req_valid = 1'b0, req_miss = 1'b0;
    logic [SET_W-1:0] req_set = '0;
    logic [WAY_W-1:0] req_way = '0;
    logic req_ready, resp_valid, resp_remapped, resp_evicted, resp_random;
    logic [WAY_W-1:0] resp_way;

    always #4 clk = ~clk;

    remap_rrip_insert #(.SETS(SETS), .WAYS(WAYS)) u_remap_rrip_insert (
        .clk(clk), .rst_n(rst_n), .remap_limit(remap_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_miss(req_miss),
        .req_set(req_set), .req_way(req_way), .resp_valid(resp_valid),
        .resp_way(resp_way), .resp_remapped(resp_remapped),
        .resp_evicted(resp_evicted), .resp_random(resp_random));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    int m_valid [SETS][WAYS];
    int m_rr    [SETS][WAYS];
    int m_rm    [SETS][WAYS];
    int m_cnt   [SETS];
    logic [7:0] m_lfsr;
    logic [15:0] stim = 16'h1D2B;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic rnd(input int m, output int v);
        stim = stim ^ (stim << 7);
        stim = stim ^ (stim >> 9);
        stim = stim ^ (stim << 8);
        v = int'(stim) % m;
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_cnt[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_rr[s][w] = 3; m_rm[s][w] = 0;
            end
        end
        m_lfsr = 8'hA5;
    endtask

    task automatic do_reset(input int lim);
        @(negedge clk);
        rst_n = 1'b0;
        remap_limit = CNT_W'(lim);
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic model_miss(input int s, input int j, input int lim,
                              output int way, output int remap, output int evict,
                              output int rn, output int ages, output string tag);
        bit fin = 0;
        int start;
        way = j; remap = 0; evict = 0; rn = 0; ages = 0; tag = "R2";
        while (!fin) begin
            fin = 1;
            if (m_valid[s][j] == 0) begin
                way = j; tag = "R2";
            end else if (m_rr[s][j] >= 2) begin
                way = j; evict = 1; tag = "R3";
            end else if (m_cnt[s] >= lim) begin
                bit got = 0;
                evict = 1;
                for (int w = 0; w < WAYS; w++)
                    if (!got && w != j && m_valid[s][w] && m_rm[s][w] && m_rr[s][w] == 3) begin
                        got = 1; way = w; remap = 1; tag = "R7";
                    end
                if (!got) begin
                    start = int'(m_lfsr) % (1 << WAY_W);
                    for (int k = 0; k < WAYS; k++) begin
                        int p = (start + k) % WAYS;
                        if (!got && p != j && m_valid[s][p] && m_rm[s][p]) begin
                            got = 1; way = p; remap = 1; rn = 1; tag = "R8";
                        end
                    end
                    if (got) m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
                    else begin way = j; tag = "R9"; end
                end
            end else begin
                bit got = 0;
                for (int w = 0; w < WAYS; w++)
                    if (!got && w != j && !m_valid[s][w]) begin
                        got = 1; way = w; remap = 1; tag = "R5";
                    end
                for (int w = 0; w < WAYS; w++)
                    if (!got && w != j && m_rr[s][w] == 3) begin
                        got = 1; way = w; remap = 1; evict = 1;
                        tag = (ages > 0) ? "R6" : "R5";
                    end
                if (!got) begin
                    for (int w = 0; w < WAYS; w++) if (w != j) m_rr[s][w]++;
                    ages++;
                    fin = 0;
                end
            end
        end
        if (evict && m_rm[s][way]) m_cnt[s]--;
        if (remap) m_cnt[s]++;
        m_valid[s][way] = 1; m_rr[s][way] = 2; m_rm[s][way] = remap;
    endtask

    task automatic do_miss(input int s, input int j, input string force_tag);
        int way, remap, evict, rn, ages, n;
        string tag;
        model_miss(s, j, int'(remap_limit), way, remap, evict, rn, ages, tag);
        if (force_tag != "") tag = force_tag;
        chk("R12", "ready before miss", int'(req_ready), 1);
        req_valid = 1'b1; req_miss = 1'b1;
        req_set = SET_W'(s); req_way = WAY_W'(j);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "ready while busy", int'(req_ready), 0);
        n = 1;
        while (!resp_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (!resp_valid) begin
            chk("R12", "response timeout", 0, 1);
        end else begin
            chk(tag, "way", int'(resp_way), way);
            chk(tag, "remapped", int'(resp_remapped), remap);
            chk(tag, "evicted", int'(resp_evicted), evict);
            chk(tag, "random", int'(resp_random), rn);
            chk((ages > 0) ? "R6" : "R12", "latency", n, 2 + 2 * ages);
            @(negedge clk);
            chk("R12", "pulse ends", int'(resp_valid), 0);
            chk("R12", "ready returns", int'(req_ready), 1);
        end
    endtask

    task automatic do_hit(input int s, input int w);
        req_valid = 1'b1; req_miss = 1'b0;
        req_set = SET_W'(s); req_way = WAY_W'(w);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "ready after hit", int'(req_ready), 1);
        chk("R11", "no response on hit", int'(resp_valid), 0);
        if (m_valid[s][w] != 0) m_rr[s][w] = 0;
    endtask

    initial begin
        do_reset(2);
        chk("R1", "ready after reset", int'(req_ready), 1);
        chk("R1", "resp_valid after reset", int'(resp_valid), 0);
        do_miss(0, 1, "R1");
        do_miss(0, 1, "R10");
        do_hit(0, 1);
        do_miss(0, 1, "R11");
        do_hit(2, 3);
        do_miss(2, 3, "R11");
        for (int w = 0; w < WAYS; w++) do_miss(1, w, "R2");
        for (int w = 0; w < WAYS; w++) do_hit(1, w);
        do_miss(1, 0, "R6");
        do_miss(1, 0, "R4");

        for (int lim = 0; lim <= WAYS; lim++) begin
            do_reset(lim);
            for (int op = 0; op < 160; op++) begin
                int kind, s, w;
                rnd(10, kind);
                rnd(2, s);
                rnd(WAYS, w);
                if (kind < 4) do_hit(s, w);
                else do_miss(s, w, "");
            end
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule